// File: doc/BRIEF.md
# Carry-Select Adder

This block adds two unsigned operands and a carry input. The operands are split into equal sections. The lowest section is a plain ripple adder driven by the real carry input. Each higher section holds two copies of the same ripple adder, one with its carry input tied low and one tied high. Both copies start work at the same moment as the lowest section, so they do not wait for the carry below them. When the carry from the section below is known, it drives only the select lines of a bank of 2:1 multiplexers. These pick the sum bits and the section carry-out from the matching copy.

With the default parameters there are two 4-bit sections, so the adder is 8 bits wide. The upper section has SEC_W+1 = five multiplexers: four for its sum bits and one for its carry-out. The adder core is purely combinational. It feeds an output register, so a result appears one clock after its operands are presented. A synchronous active-high reset clears that register.

Top module: `csel_adder`

## Requirements
- R1: In the cycle after a clock edge at which `rst` is 1, `sum_q` is 0 and `carry_out_q` is 0.
- R2: At every clock edge with `rst` at 0, the register takes `{carry_out_q, sum_q}` = `op_a + op_b + carry_in` as a 9-bit unsigned value. That value is visible after the edge.
- R3: Bits [3:0] of `sum_q` equal the low four bits of `op_a[3:0] + op_b[3:0] + carry_in`, taken from the operands at the previous edge.
- R4: When `op_a[3:0] + op_b[3:0] + carry_in` is below 16 (no carry into bit 4), bits [7:4] of `sum_q` equal the low four bits of `op_a[7:4] + op_b[7:4]`.
- R5: When `op_a[3:0] + op_b[3:0] + carry_in` is 16 or more (carry into bit 4), bits [7:4] of `sum_q` equal the low four bits of `op_a[7:4] + op_b[7:4] + 1`.
- R6: These boundary cases give the stated results:
  - 0xFF + 0x00 + 1 = 0x100, with the carry running through every bit.
  - 0x0F + 0x00 + 1 = 0x010.
  - 0xF0 + 0x10 + 0 = 0x100.
  - 0xFF + 0xFF + 1 = 0x1FF.
  - 0x00 + 0x00 + 0 = 0x000.
- R7: R2 holds for all 2^17 combinations of `op_a`, `op_b` and `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | SEC_W*NSEC (8) | First operand |
| op_b | input | SEC_W*NSEC (8) | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_q | output | SEC_W*NSEC (8) | Registered sum |
| carry_out_q | output | 1 | Registered carry out of the top bit |

## Verification
The bound checker checks on every cycle:
- the cleared output after reset;
- the full registered sum against the operands one edge earlier;
- the low-section sum;
- the upper-section sum under each value of the section carry, so a fault in either speculative copy or in the select polarity is caught whenever that branch is taken.

Only the bench's scenarios show that every branch is actually exercised. The named boundary patterns prove that a carry survives across the section seam. The full 2^17 sweep closes every input combination, including the all-ones propagate chain.

// File: rtl/csel_pkg.sv
package csel_pkg;
  parameter int unsigned CSEL_SEC_W = 4;
  parameter int unsigned CSEL_NSEC  = 2;

  typedef enum logic {
    GUESS_C0 = 1'b0,
    GUESS_C1 = 1'b1
  } carry_guess_e;
endpackage

// File: rtl/csel_fa.sv
module csel_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic hx;
  assign hx = x ^ y;
  assign s  = hx ^ ci;
  assign co = (x & y) | (ci & hx);
endmodule

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] chain;
  assign chain[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    csel_fa u_fa (
      .x (x[i]),
      .y (y[i]),
      .ci(chain[i]),
      .s (s[i]),
      .co(chain[i+1])
    );
  end

  assign co = chain[W];
endmodule

// File: rtl/csel_spec_section.sv
module csel_spec_section
  import csel_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sel,
  output logic [W-1:0] s,
  output logic         co
);
  localparam int unsigned MUXN = W + 1;

  logic [W-1:0]  s_g0, s_g1;
  logic          co_g0, co_g1;
  logic [MUXN-1:0] res_g0, res_g1, res_pick;

  csel_ripple #(.W(W)) u_guess0 (
    .x(x), .y(y), .ci(GUESS_C0), .s(s_g0), .co(co_g0)
  );

  csel_ripple #(.W(W)) u_guess1 (
    .x(x), .y(y), .ci(GUESS_C1), .s(s_g1), .co(co_g1)
  );

  assign res_g0 = {co_g0, s_g0};
  assign res_g1 = {co_g1, s_g1};

  for (genvar m = 0; m < MUXN; m++) begin : g_mux
    assign res_pick[m] = sel ? res_g1[m] : res_g0[m];
  end

  assign s  = res_pick[W-1:0];
  assign co = res_pick[W];
endmodule

// File: rtl/csel_core.sv
module csel_core #(
  parameter int unsigned SEC_W = 4,
  parameter int unsigned NSEC  = 2
) (
  input  logic [SEC_W*NSEC-1:0] x,
  input  logic [SEC_W*NSEC-1:0] y,
  input  logic                  ci,
  output logic [SEC_W*NSEC-1:0] s,
  output logic                  co
);
  logic [NSEC:0] sec_c;
  assign sec_c[0] = ci;

  csel_ripple #(.W(SEC_W)) u_low (
    .x (x[SEC_W-1:0]),
    .y (y[SEC_W-1:0]),
    .ci(sec_c[0]),
    .s (s[SEC_W-1:0]),
    .co(sec_c[1])
  );

  for (genvar k = 1; k < NSEC; k++) begin : g_sec
    csel_spec_section #(.W(SEC_W)) u_sec (
      .x  (x[k*SEC_W +: SEC_W]),
      .y  (y[k*SEC_W +: SEC_W]),
      .sel(sec_c[k]),
      .s  (s[k*SEC_W +: SEC_W]),
      .co (sec_c[k+1])
    );
  end

  assign co = sec_c[NSEC];
endmodule

// File: rtl/csel_adder.sv
module csel_adder
  import csel_pkg::*;
#(
  parameter int unsigned SEC_W = CSEL_SEC_W,
  parameter int unsigned NSEC  = CSEL_NSEC
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SEC_W*NSEC-1:0] op_a,
  input  logic [SEC_W*NSEC-1:0] op_b,
  input  logic                  carry_in,
  output logic [SEC_W*NSEC-1:0] sum_q,
  output logic                  carry_out_q
);
  localparam int unsigned DW = SEC_W * NSEC;

  logic [DW-1:0] sum_c;
  logic          co_c;

  csel_core #(.SEC_W(SEC_W), .NSEC(NSEC)) u_core (
    .x (op_a),
    .y (op_b),
    .ci(carry_in),
    .s (sum_c),
    .co(co_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q       <= '0;
      carry_out_q <= 1'b0;
    end else begin
      sum_q       <= sum_c;
      carry_out_q <= co_c;
    end
  end
endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk #(
  parameter int unsigned SEC_W = 4,
  parameter int unsigned NSEC  = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic [SEC_W*NSEC-1:0] op_a,
  input logic [SEC_W*NSEC-1:0] op_b,
  input logic                  carry_in,
  input logic [SEC_W*NSEC-1:0] sum_q,
  input logic                  carry_out_q
);
  localparam int unsigned DW = SEC_W * NSEC;

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  logic [DW:0]    ref_total;
  logic [SEC_W:0] ref_low, ref_up0, ref_up1;
  assign ref_total = {1'b0, op_a} + {1'b0, op_b} + (DW+1)'(carry_in);
  assign ref_low   = {1'b0, op_a[SEC_W-1:0]} + {1'b0, op_b[SEC_W-1:0]} + (SEC_W+1)'(carry_in);
  assign ref_up0   = {1'b0, op_a[2*SEC_W-1:SEC_W]} + {1'b0, op_b[2*SEC_W-1:SEC_W]};
  assign ref_up1   = ref_up0 + (SEC_W+1)'(1);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && !carry_out_q));

  assert_total_R2: assert property (@(posedge clk) disable iff (rst)
    armed |-> ({carry_out_q, sum_q} == $past(ref_total)));

  assert_low_sec_R3: assert property (@(posedge clk) disable iff (rst)
    armed |-> (sum_q[SEC_W-1:0] == $past(ref_low[SEC_W-1:0])));

  assert_upper_c0_R4: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(ref_low[SEC_W])) |->
      (sum_q[2*SEC_W-1:SEC_W] == $past(ref_up0[SEC_W-1:0])));

  assert_upper_c1_R5: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(ref_low[SEC_W])) |->
      (sum_q[2*SEC_W-1:SEC_W] == $past(ref_up1[SEC_W-1:0])));
endmodule

bind csel_adder csel_adder_chk #(.SEC_W(SEC_W), .NSEC(NSEC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_a       (op_a),
  .op_b       (op_b),
  .carry_in   (carry_in),
  .sum_q      (sum_q),
  .carry_out_q(carry_out_q)
);

// File: tb/sim_csel_adder.sv
`timescale 1ns/1ps
module sim_csel_adder;
  localparam int W = 8;
  localparam int WATCHDOG = 190000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] sum_q;
  logic         carry_out_q;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [W:0]   exp_q[$];
  logic [2*W:0] in_q[$];
  int           tag_q[$];

  always #5 clk = ~clk;

  csel_adder u0 (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum_q(sum_q), .carry_out_q(carry_out_q)
  );

  function automatic string tag_name(int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic c, input int tag);
    @(negedge clk);
    op_a = a; op_b = b; carry_in = c;
    exp_q.push_back({1'b0, a} + {1'b0, b} + (W+1)'(c));
    in_q.push_back({c, b, a});
    tag_q.push_back(tag);
  endtask

  // monitor: result of operands pushed before this edge appears after it
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [W:0]   e;
      logic [2*W:0] iv;
      int           t;
      logic         lc;
      string        rq;
      e  = exp_q.pop_front();
      iv = in_q.pop_front();
      t  = tag_q.pop_front();
      total++;
      if ({carry_out_q, sum_q} !== e) begin
        bad++;
        lc = (({1'b0, iv[3:0]} + {1'b0, iv[W+3:W]} + 5'(iv[2*W])) > 5'd15);
        rq = tag_name(t);
        if (sum_q[3:0] !== e[3:0]) rq = {rq, "/R3"};
        else if (sum_q[7:4] !== e[7:4]) rq = {rq, lc ? "/R5" : "/R4"};
        $display("FAIL %s a=%0h b=%0h cin=%0b actual=%0h expected=%0h",
                 rq, iv[W-1:0], iv[2*W-1:W], iv[2*W], {carry_out_q, sum_q}, e);
      end
    end
  end

  task automatic check_reset();
    @(posedge clk); #2;
    total++;
    if (sum_q !== '0 || carry_out_q !== 1'b0) begin
      bad++;
      $display("FAIL R1 actual=%0h expected=0", {carry_out_q, sum_q});
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset clears the output register, even with busy operands
    op_a = 8'hA5; op_b = 8'h7E; carry_in = 1'b1;
    repeat (2) @(posedge clk);
    check_reset();
    @(negedge clk); rst = 1'b0;
    // R2: general patterns
    drive(8'h12, 8'h34, 1'b0, 2);
    drive(8'h80, 8'h80, 1'b0, 2);
    drive(8'h5A, 8'hA5, 1'b1, 2);
    // R3: low section with real carry in
    drive(8'h07, 8'h08, 1'b1, 3);
    drive(8'h09, 8'h06, 1'b0, 3);
    // R4: no carry into the upper section
    drive(8'h73, 8'h24, 1'b0, 4);
    drive(8'hF1, 8'h0E, 1'b0, 4);
    // R5: carry into the upper section picks the +1 copy
    drive(8'h3C, 8'h48, 1'b0, 5);
    drive(8'hEF, 8'h00, 1'b1, 5);
    // R6: boundary cases
    drive(8'hFF, 8'h00, 1'b1, 6);
    drive(8'h0F, 8'h00, 1'b1, 6);
    drive(8'hF0, 8'h10, 1'b0, 6);
    drive(8'hFF, 8'hFF, 1'b1, 6);
    drive(8'h00, 8'h00, 1'b0, 6);
    // R7: every combination
    for (int v = 0; v < (1 << (2*W+1)); v++) begin
      drive(v[W-1:0], v[2*W-1:W], v[2*W], 7);
    end
    repeat (3) @(posedge clk);
    // R1 again: mid-run reset
    @(negedge clk);
    rst = 1'b1; op_a = 8'hFF; op_b = 8'hFF; carry_in = 1'b1;
    check_reset();
    @(negedge clk); rst = 1'b0;
    drive(8'h01, 8'hFE, 1'b1, 2);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule